// File: doc/BRIEF.md
# Flash Strobe and Wait-State Acknowledge Generator

This block drives the control strobes of an on-board parallel flash device and answers accesses from the target bus with a data-transfer acknowledge. A primary chip select is steered by a board strap. In the flash position it selects the flash. In the target position it goes to the target hardware. A second chip select always goes to the target hardware.

Flash output enable and write enable are decoded directly from the primary chip select, the strap and the read/write direction. Flash reset mirrors the active-low system reset.

Accesses that go to the target hardware are answered only after a fixed number of wait states. A small registered counter measures these wait states. The acknowledge is presented as a value plus a drive enable, so that a pad or bus-sharing stage outside the block can release the line whenever no target access is in flight.

Top module: `flash_strobe_ack`

## Requirements
- R1: The flash counts as selected only while `cs0_n` is 0 and `route_flash` is 1. Whenever it is not selected, `flash_oe_n` and `flash_we_n` are both 1, whatever the value of `rd_wr`.
- R2: While the flash is selected with `rd_wr` = 1 (read), `flash_oe_n` is 0 and `flash_we_n` is 1.
- R3: While the flash is selected with `rd_wr` = 0 (write), `flash_we_n` is 0 and `flash_oe_n` is 1.
- R4: `flash_oe_n` and `flash_we_n` are never 0 at the same time.
- R5: `flash_rst_n` equals `rst_n` at all times.
- R6: An acknowledged access is one of the following: `cs0_n` = 0 with `route_flash` = 0, or `cs1_n` = 0. A flash-routed `cs0_n` access by itself never enables the acknowledge driver.
- R7: During an acknowledged access, `ack_n` is 1 in the first WAIT_STATES clocks (default 2) and becomes 0 from clock WAIT_STATES+1 (the third clock by default).
- R8: `ack_n` stays 0 for as long as the access continues. It is still 0, and still driven, in the clock after the chip select negates, and it is released in the clock after that.
- R9: With no access in flight and the wait counter at zero, `ack_en` is 0 and `ack_n` is 1.
- R10: When `rst_n` is 0 at a rising clock edge, the wait counter clears. An access still in progress then restarts its wait states from the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cs0_n | input | 1 | Primary chip select, active-low |
| route_flash | input | 1 | Strap: 1 routes `cs0_n` to the flash, 0 to the target hardware |
| cs1_n | input | 1 | Second chip select, active-low, always target-routed |
| rd_wr | input | 1 | Transfer direction: 1 read, 0 write |
| flash_we_n | output | 1 | Flash write enable, active-low |
| flash_oe_n | output | 1 | Flash output enable, active-low |
| flash_rst_n | output | 1 | Flash reset, active-low |
| ack_n | output | 1 | Data-transfer acknowledge value, active-low |
| ack_en | output | 1 | Drive enable for `ack_n`; 0 means the line is released |

## Verification
The bench builds the block with WAIT_STATES at its default of 2. This value covers the case where the count reaches its limit and saturates during a long access. It also covers the release cycle after a chip select negates. The same value lets the bench set up a one-clock access that ends before any acknowledge is given, and a reset that arrives partway through a counted access, without long runs. The vector table switches between the primary and secondary chip selects and flips the strap in both directions. This shows that flash-routed accesses keep the acknowledge driver off.

// File: rtl/fsa_pkg.sv
// Package: shared types for the flash strobe / acknowledge generator.
// Assumes: all strobes are active-low; the strap is static during an access.
package fsa_pkg;

    typedef enum logic {
        ROUTE_TARGET = 1'b0,
        ROUTE_FLASH  = 1'b1
    } route_e;

    typedef struct packed {
        logic we_n;
        logic oe_n;
    } flash_strobe_t;

endpackage

// File: rtl/fsa_route_decode.sv
// Module: fsa_route_decode
// Decodes the chip selects and the strap. It produces the flash strobes and
// the "acknowledged access" qualifier.
// Assumes: inputs are synchronous to the system clock; purely combinational.
module fsa_route_decode
    import fsa_pkg::*;
(
    input  logic          cs0_n,
    input  logic          route_flash,
    input  logic          cs1_n,
    input  logic          rd_wr,
    output flash_strobe_t strobe,
    output logic          ack_qual
);

    logic flash_sel;
    logic tgt_cs0;

    // Split the primary chip select by strap position.
    always_comb begin
        flash_sel = !cs0_n && (route_e'(route_flash) == ROUTE_FLASH);
        tgt_cs0   = !cs0_n && (route_e'(route_flash) == ROUTE_TARGET);
    end

    // Drive one flash strobe per direction, only while the flash is selected.
    always_comb begin
        strobe.oe_n = !(flash_sel && rd_wr);
        strobe.we_n = !(flash_sel && !rd_wr);
    end

    // Mark the accesses that must be answered with a delayed acknowledge.
    always_comb begin
        ack_qual = tgt_cs0 || !cs1_n;
    end

endmodule

// File: rtl/fsa_wait_counter.sv
// Module: fsa_wait_counter
// Counts wait states during an acknowledged access and produces the
// acknowledge value and its drive enable.
// Assumes: ack_qual is held for the whole access; synchronous active-low reset.
module fsa_wait_counter #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_qual,
    output logic ack_n_o,
    output logic ack_en_o
);

    localparam int CW = $clog2(WAIT_STATES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAIT_STATES);

    logic [CW-1:0] cnt;

    // Advance once per clock while the access lasts; saturate; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!ack_qual) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Acknowledge once the limit is reached; drive while counting or accessing.
    always_comb begin
        ack_n_o  = (cnt != LIMIT);
        ack_en_o = ack_qual || (cnt != '0);
    end

    // R9/R10: an idle cycle leaves the counter at zero on the next clock
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_qual |=> (cnt == '0));

    // R7: the counter advances by one each clock until the limit
    p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_qual && cnt != LIMIT) |=> (cnt == $past(cnt) + 1'b1));

    // R7: no acknowledge in the first clock of an access
    p_first_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_qual && cnt == '0) |-> ack_n_o);

    // R8: once given, the acknowledge persists while the access lasts
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_qual && !ack_n_o) |=> !ack_n_o);

endmodule

// File: rtl/flash_strobe_ack.sv
// Module: flash_strobe_ack (top)
// Produces the flash control strobes and the wait-stated acknowledge for
// target-routed accesses.
// Assumes: synchronous active-low reset; an external pad stage uses ack_en
// to release the shared acknowledge line.
module flash_strobe_ack
    import fsa_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs0_n,
    input  logic route_flash,
    input  logic cs1_n,
    input  logic rd_wr,
    output logic flash_we_n,
    output logic flash_oe_n,
    output logic flash_rst_n,
    output logic ack_n,
    output logic ack_en
);

    flash_strobe_t strobe;
    logic          ack_qual;

    fsa_route_decode u_decode (
        .cs0_n       (cs0_n),
        .route_flash (route_flash),
        .cs1_n       (cs1_n),
        .rd_wr       (rd_wr),
        .strobe      (strobe),
        .ack_qual    (ack_qual)
    );

    fsa_wait_counter #(
        .WAIT_STATES (WAIT_STATES)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_qual (ack_qual),
        .ack_n_o  (ack_n),
        .ack_en_o (ack_en)
    );

    // Present the decoded strobes and pass the system reset to the flash.
    always_comb begin
        flash_we_n  = strobe.we_n;
        flash_oe_n  = strobe.oe_n;
        flash_rst_n = rst_n;
    end

    // R4: the flash never sees both strobes at once
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));

    // R6: a held flash-only access keeps the acknowledge driver off
    p_flash_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs0_n && route_flash && cs1_n && $past(!cs0_n && route_flash && cs1_n))
        |-> !ack_en);

    // R1: strobes stay inactive with the primary select negated
    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs0_n |-> (flash_we_n && flash_oe_n));

endmodule

// File: tb/flash_strobe_ack_test.sv
module flash_strobe_ack_test;

    localparam int PERIOD = 10;
    localparam int NVEC   = 26;

    // {rst_n, cs0_n, route_flash, cs1_n, rd_wr, exp_we_n, exp_oe_n, exp_frst_n, exp_ack_n, exp_ack_en}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0_1_1_1_1_1_1_0_1_0, // 0  reset, idle (R5, R9)
        10'b1_1_1_1_1_1_1_1_1_0, // 1  idle (R9)
        10'b1_0_0_1_1_1_1_1_1_1, // 2  target cs0, clock 1 (R6, R7, R1)
        10'b1_0_0_1_1_1_1_1_1_1, // 3  clock 2 (R7)
        10'b1_0_0_1_1_1_1_1_0_1, // 4  clock 3 ack (R7)
        10'b1_0_0_1_1_1_1_1_0_1, // 5  held (R8)
        10'b1_1_0_1_1_1_1_1_0_1, // 6  cs negated, ack still driven (R8)
        10'b1_1_0_1_1_1_1_1_1_0, // 7  released (R8, R9)
        10'b1_0_1_1_1_1_0_1_1_0, // 8  flash read (R2, R6)
        10'b1_0_1_1_1_1_0_1_1_0, // 9  flash read held (R6)
        10'b1_0_1_1_0_0_1_1_1_0, // 10 flash write (R3)
        10'b1_1_1_1_0_1_1_1_1_0, // 11 idle
        10'b1_1_1_0_1_1_1_1_1_1, // 12 cs1 clock 1 (R6)
        10'b1_1_1_0_1_1_1_1_1_1, // 13 cs1 clock 2 (R7)
        10'b1_1_1_0_1_1_1_1_0_1, // 14 cs1 ack (R7)
        10'b1_1_1_1_1_1_1_1_0_1, // 15 release cycle (R8)
        10'b1_1_1_1_1_1_1_1_1_0, // 16 idle
        10'b1_1_1_0_1_1_1_1_1_1, // 17 cs1 clock 1
        10'b1_1_1_0_1_1_1_1_1_1, // 18 cs1 clock 2
        10'b0_1_1_0_1_1_1_0_0_1, // 19 reset mid-access (R10, R5)
        10'b1_1_1_0_1_1_1_1_1_1, // 20 restarted from clock 1 (R10)
        10'b1_1_1_1_1_1_1_1_1_1, // 21 counter at 1, still driven
        10'b1_1_1_1_1_1_1_1_1_0, // 22 idle
        10'b1_0_0_1_0_1_1_1_1_1, // 23 target write: no flash strobe (R1)
        10'b1_1_0_1_0_1_1_1_1_1, // 24 counter at 1
        10'b1_1_0_1_0_1_1_1_1_0  // 25 idle
    };

    logic clk = 1'b0;
    logic rst_n, cs0_n, route_flash, cs1_n, rd_wr;
    logic flash_we_n, flash_oe_n, flash_rst_n, ack_n, ack_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    flash_strobe_ack uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs0_n       (cs0_n),
        .route_flash (route_flash),
        .cs1_n       (cs1_n),
        .rd_wr       (rd_wr),
        .flash_we_n  (flash_we_n),
        .flash_oe_n  (flash_oe_n),
        .flash_rst_n (flash_rst_n),
        .ack_n       (ack_n),
        .ack_en      (ack_en)
    );

    task automatic check(input string req, input int idx, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s step %0d: actual %b expected %b", req, idx, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic c0, input logic rf, input logic c1, input logic rw);
        rst_n = r; cs0_n = c0; route_flash = rf; cs1_n = c1; rd_wr = rw;
    endtask

    initial begin
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        // vector table: each entry is one clock, driven at negedge, sampled 2 units later
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
            #2;
            check("R3", i, flash_we_n,  VEC[i][4]);
            check("R2", i, flash_oe_n,  VEC[i][3]);
            check("R5", i, flash_rst_n, VEC[i][2]);
            check("R7", i, ack_n,       VEC[i][1]);
            check("R9", i, ack_en,      VEC[i][0]);
            check("R4", i, !(!flash_we_n && !flash_oe_n), 1'b1);
        end
        // R8: long target access, ack stays low from the third clock on
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
            #2;
            check("R8", 100 + k, ack_n, (k >= 2) ? 1'b0 : 1'b1);
        end
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        #2;
        check("R8", 112, ack_n, 1'b0);
        @(negedge clk);
        #2;
        check("R8", 113, ack_en, 1'b0);
        // R7: one-clock access never acknowledges
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        #2;
        check("R7", 114, ack_n, 1'b1);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        #2;
        check("R7", 115, ack_n, 1'b1);
        @(negedge clk);
        #2;
        check("R9", 116, ack_en, 1'b0);
        // R6: flash and cs1 together still count as acknowledged access
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        #2;
        check("R6", 117, ack_en, 1'b1);
        check("R2", 117, flash_oe_n, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule